// File: doc/BRIEF.md
# Radix-4 Offset-Binary Partial-Product Generator

This block forms one partial product for a distributed-arithmetic datapath in which the coefficients are held in offset-binary form. Each cycle it takes a signed sample and two adjacent coefficient bits. It reads the bit pair as a single radix-4 digit taken from the set {-3, -1, +1, +3}, and it returns that digit times the sample. A separate flag tells the block that the bit pair sits at the coefficient's sign position. At that position the digit convention is mirrored.

Because the digit set has odd values only, two magnitudes are enough: the sample itself and three times the sample. The block computes the triple locally. A small decoder turns the bit pair into two one-hot magnitude selects and a negate flag. An AND-OR encoder picks the magnitude, and an XOR stage inverts it for negative digits. The negation is left incomplete: the missing +1 comes out as a carry bit that the downstream adder takes as its carry-in. All outputs are registered once.

Top module: `opp_radix4_ppg`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both `pp_o` and `cin_o` are zero after that edge.
- R2: The outputs after a rising edge depend only on the inputs sampled at that same edge, which gives a latency of one cycle.
- R3: With `sign_pos_i` = 0, the pair {`coef_hi_i`,`coef_lo_i`} selects the digit as follows: 00 gives +1, 01 gives +3, 10 gives -3 and 11 gives -1.
- R4: With `sign_pos_i` = 1, the same pairs select mirrored digits: 00 gives -3, 01 gives -1, 10 gives +1 and 11 gives +3.
- R5: `pp_o` is a two's-complement word of B+2 bits. The signed value of `pp_o` plus `cin_o` equals the digit times the signed B-bit `sample_i`.
- R6: `cin_o` is 1 exactly when the selected digit is negative, and this holds even for a zero sample. For a positive digit, `pp_o` alone is the product.
- R7: No input combination overflows, including the most negative sample with digit ±3. Bit B+1 of `pp_o` equals the sample's sign bit XOR `cin_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | B | Signed input sample |
| coef_hi_i | input | 1 | Upper bit of the coefficient bit pair |
| coef_lo_i | input | 1 | Lower bit of the coefficient bit pair |
| sign_pos_i | input | 1 | Marks the pair as taken at the coefficient sign position |
| pp_o | output | B+2 | Partial product, inverted when the digit is negative |
| cin_o | output | 1 | Completing carry-in for the downstream adder |

## Verification
Every result is due exactly one rising edge after its inputs are presented. The reference model therefore holds one queued expectation per applied stimulus. Inputs are driven on the falling edge, and each expectation is compared on the following falling edge, by which time the capturing rising edge has passed. The value check and the carry check are made separately for every digit/flag combination, for the extreme and zero samples, and for random samples, so that a wrong sign convention cannot hide inside a correct sum.

// File: rtl/opp_pkg.sv
// Package: shared decode type for the radix-4 offset-binary generator.
// Assumes one digit per cycle; the selects are one-hot by construction.
package opp_pkg;

    typedef struct packed {
        logic sel_one;    // magnitude is |x|-path (x)
        logic sel_three;  // magnitude is 3x path
        logic negate;     // digit is negative
    } opp_dec_t;

endpackage

// File: rtl/opp_digit_decode.sv
// Module: opp_digit_decode
// Turns a coefficient bit pair into magnitude selects and a negate flag.
// Assumes: sign_pos mirrors the digit set (magnitude selects swap, sign flips).
module opp_digit_decode
    import opp_pkg::*;
(
    input  logic     hi_i,
    input  logic     lo_i,
    input  logic     sign_pos_i,
    output opp_dec_t dec_o
);

    logic pair_diff;

    // Purpose: XOR picks the three-magnitude, XNOR the one-magnitude; flag swaps.
    always_comb begin
        pair_diff       = hi_i ^ lo_i;
        dec_o.sel_three = pair_diff ^ sign_pos_i;
        dec_o.sel_one   = ~(pair_diff ^ sign_pos_i);
        dec_o.negate    = hi_i ^ sign_pos_i;
    end

endmodule

// File: rtl/opp_triple_gen.sv
// Module: opp_triple_gen
// Sign-extends a signed sample to the output width and forms x and 3x.
// Assumes: OW >= IW + 2 so that 3x never overflows.
module opp_triple_gen #(
    parameter int IW = 8,
    parameter int OW = IW + 2
) (
    input  logic [IW-1:0] x_i,
    output logic [OW-1:0] x1_o,
    output logic [OW-1:0] x3_o
);

    localparam int EXT = OW - IW;

    logic [OW-1:0] x_ext;
    logic [OW-1:0] x_dbl;

    // Purpose: sign extension, doubling and the single add for the triple.
    always_comb begin
        x_ext = {{EXT{x_i[IW-1]}}, x_i};
        x_dbl = {x_ext[OW-2:0], 1'b0};
        x1_o  = x_ext;
        x3_o  = x_ext + x_dbl;
    end

endmodule

// File: rtl/opp_select_encode.sv
// Module: opp_select_encode
// Bitwise AND-OR selection of x or 3x, followed by XOR sign reversal.
// Assumes: exactly one of the selects is high (decoder guarantees it).
module opp_select_encode
    import opp_pkg::*;
#(
    parameter int OW = 10
) (
    input  opp_dec_t      dec_i,
    input  logic [OW-1:0] x1_i,
    input  logic [OW-1:0] x3_i,
    output logic [OW-1:0] pp_o,
    output logic          cin_o
);

    for (genvar b = 0; b < OW; b++) begin : g_bit
        logic mag_bit;
        // Purpose: per-bit AND-OR magnitude pick, then conditional inversion.
        always_comb begin
            mag_bit = (dec_i.sel_one & x1_i[b]) | (dec_i.sel_three & x3_i[b]);
            pp_o[b] = mag_bit ^ dec_i.negate;
        end
    end

    // Purpose: the +1 that completes the two's-complement negation.
    always_comb cin_o = dec_i.negate;

endmodule

// File: rtl/opp_radix4_ppg.sv
// Module: opp_radix4_ppg (top)
// One radix-4 offset-binary digit times a signed sample, registered once.
// Assumes: synchronous active-low reset; result = signed(pp_o) + cin_o.
module opp_radix4_ppg
    import opp_pkg::*;
#(
    parameter int B = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [B-1:0]   sample_i,
    input  logic           coef_hi_i,
    input  logic           coef_lo_i,
    input  logic           sign_pos_i,
    output logic [B+1:0]   pp_o,
    output logic           cin_o
);

    localparam int PW = B + 2;

    opp_dec_t      dec;
    logic [PW-1:0] x1;
    logic [PW-1:0] x3;
    logic [PW-1:0] pp_d;
    logic          cin_d;

    opp_digit_decode u_dec (
        .hi_i       (coef_hi_i),
        .lo_i       (coef_lo_i),
        .sign_pos_i (sign_pos_i),
        .dec_o      (dec)
    );

    opp_triple_gen #(.IW(B), .OW(PW)) u_trip (
        .x_i  (sample_i),
        .x1_o (x1),
        .x3_o (x3)
    );

    opp_select_encode #(.OW(PW)) u_enc (
        .dec_i (dec),
        .x1_i  (x1),
        .x3_i  (x3),
        .pp_o  (pp_d),
        .cin_o (cin_d)
    );

    // Purpose: output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_o  <= '0;
            cin_o <= 1'b0;
        end else begin
            pp_o  <= pp_d;
            cin_o <= cin_d;
        end
    end

endmodule

// File: rtl/opp_radix4_ppg_chk.sv
// Module: opp_radix4_ppg_chk
// Port-level temporal checks for opp_radix4_ppg, attached by bind.
module opp_radix4_ppg_chk #(
    parameter int B = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [B-1:0] sample_i,
    input logic         coef_hi_i,
    input logic         coef_lo_i,
    input logic         sign_pos_i,
    input logic [B+1:0] pp_o,
    input logic         cin_o
);

    // Purpose: behavioural digit table used only by the checks.
    function automatic int digit_of(input logic hi, input logic lo, input logic sp);
        int d;
        case ({sp, hi, lo})
            3'b000: d = 1;
            3'b001: d = 3;
            3'b010: d = -3;
            3'b011: d = -1;
            3'b100: d = -3;
            3'b101: d = -1;
            3'b110: d = 1;
            default: d = 3;
        endcase
        return d;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pp_o == '0 && !cin_o)); // R1

    AST_CARRY_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cin_o == ($past(coef_hi_i) ^ $past(sign_pos_i))); // R6

    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'($signed(pp_o)) + int'(cin_o)) ==
            digit_of($past(coef_hi_i), $past(coef_lo_i), $past(sign_pos_i))
            * int'($signed($past(sample_i)))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pp_o[B+1] == ($past(sample_i[B-1]) ^ cin_o)); // R7

endmodule

bind opp_radix4_ppg opp_radix4_ppg_chk #(.B(B)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .coef_hi_i  (coef_hi_i),
    .coef_lo_i  (coef_lo_i),
    .sign_pos_i (sign_pos_i),
    .pp_o       (pp_o),
    .cin_o      (cin_o)
);

// File: tb/sim_opp_radix4_ppg.sv
// Bench: queued behavioural reference, compared on every falling edge.
module sim_opp_radix4_ppg;

    localparam int B       = 8;
    localparam int PW      = B + 2;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [B-1:0]  sample_i = '0;
    logic          coef_hi_i = 1'b0;
    logic          coef_lo_i = 1'b0;
    logic          sign_pos_i = 1'b0;
    logic [PW-1:0] pp_o;
    logic          cin_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [PW-1:0] exp_pp_q[$];
    logic          exp_cin_q[$];
    string         tag_q[$];

    opp_radix4_ppg #(.B(B)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .coef_hi_i  (coef_hi_i),
        .coef_lo_i  (coef_lo_i),
        .sign_pos_i (sign_pos_i),
        .pp_o       (pp_o),
        .cin_o      (cin_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Purpose: digit value per the stated mappings (R3 ordinary, R4 sign position).
    function automatic int ref_digit(input logic hi, input logic lo, input logic sp);
        int tab_ord[4] = '{1, 3, -3, -1};
        int tab_sgn[4] = '{-3, -1, 1, 3};
        return sp ? tab_sgn[{hi, lo}] : tab_ord[{hi, lo}];
    endfunction

    task automatic check_pp(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pp_o actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_cin(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cin_o actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Purpose: compare the pending expectation, then drive and queue the next one.
    task automatic step(input logic [B-1:0] x, input logic hi, input logic lo, input logic sp);
        int d, p, t;
        logic neg;
        logic [PW-1:0] e;
        string base;
        @(negedge clk);
        if (exp_pp_q.size() > 0) begin
            string tg;
            tg = tag_q.pop_front();
            check_pp(pp_o, exp_pp_q.pop_front(), {tg, ",R5,R2"});
            check_cin(cin_o, exp_cin_q.pop_front(), "R6");
        end
        sample_i   = x;
        coef_hi_i  = hi;
        coef_lo_i  = lo;
        sign_pos_i = sp;
        d   = ref_digit(hi, lo, sp);
        p   = d * int'($signed(x));
        neg = (d < 0);
        t   = p - int'(neg);
        e   = t[PW-1:0];
        base = sp ? "R4" : "R3";
        if (x == {1'b1, {(B-1){1'b0}}} || x == {1'b0, {(B-1){1'b1}}})
            base = {base, ",R7"};
        exp_pp_q.push_back(e);
        exp_cin_q.push_back(neg);
        tag_q.push_back(base);
    endtask

    // Purpose: watchdog that ends a hung run as a failure.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Purpose: stimulus sequence.
    initial begin
        logic [B-1:0] corners[5];
        corners[0] = '0;
        corners[1] = {{(B-1){1'b0}}, 1'b1};
        corners[2] = '1;
        corners[3] = {1'b0, {(B-1){1'b1}}};
        corners[4] = {1'b1, {(B-1){1'b0}}};
        // R1: reset clears outputs
        sample_i = '1; coef_hi_i = 1'b1; sign_pos_i = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_pp(pp_o, '0, "R1");
            check_cin(cin_o, 1'b0, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;
        // Exhaustive digit/flag sweep over corner samples (R3, R4, R6, R7)
        for (int sp = 0; sp < 2; sp++)
            for (int pr = 0; pr < 4; pr++)
                for (int c = 0; c < 5; c++)
                    step(corners[c], pr[1], pr[0], sp[0]);
        // Random samples and digits (R2: back-to-back changes each cycle)
        void'($urandom(32'h5eed));
        for (int i = 0; i < 400; i++)
            step(B'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        step('0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule